// File: doc/BRIEF.md
# Configuration Header Address Window Bank

This block holds the six base address registers and the expansion ROM base register of a type-0 configuration header, together with the two space-enable bits of the command register. Each region has a fixed power-of-two size and a fixed kind, I/O or memory, both set by parameters. A configuration write stores only the address bits that the region size leaves free. Sizing software therefore reads back the size after it writes all ones.

From the stored registers and the command enables, the block produces a registered base address and a valid flag for every region. A window is valid only when its space is enabled and its base is non-zero. It must not run past the top of the 32-bit space. An I/O window must also end below the 64 KiB I/O limit. The ROM window additionally needs its own enable bit. A separate decoder can use these outputs directly to claim bus cycles.

Top module: `cfgbar_bank`

## Requirements
- R1: After synchronous reset every stored register and both command enables are zero, every region_valid bit is 0, and cfg_rdata is zero.
- R2: A write with cfg_be = 4'hF and cfg_addr[1:0] = 0 to dword offset 0x10 + 4*i (i below NUM_BARS) stores cfg_wdata AND NOT(size_i - 1) into address register i.
- R3: A write to an address register with any cfg_be other than 4'hF leaves the stored value unchanged.
- R4: Reading an address register returns the stored value with bit 0 forced to 1 for an I/O region and 0 for a memory region, so writing all ones reads back NOT(size - 1) OR that type bit.
- R5: A full-dword write to offset 0x30 stores the ROM register as cfg_wdata AND (NOT(rom_size - 1) OR 1), keeping bit 0 as the ROM enable; reads return the stored value.
- R6: The command register sits at offset 0x04; byte lane 0 bit 0 enables I/O regions and bit 1 enables memory regions, and all other bits read as 0. An I/O region can be valid only with bit 0 set, a memory region only with bit 1 set.
- R7: A region whose masked base is zero is never valid.
- R8: An I/O region whose last address (base + size - 1) is 0x10000 or higher is invalid; a window ending at 0xFFFF is valid. A window whose last address carries past bit 31 is invalid.
- R9: The ROM region is valid only when its stored bit 0 is 1 and the memory enable is set; the ROM is always a memory region.
- R10: region_base carries the masked base with the type and enable bits cleared, and region_base and region_valid reflect a write accepted at clock edge E from edge E+1 on.
- R11: A read (cfg_rd) accepted at an edge returns at that edge the register contents from before any write accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| region_base | output | 32*NREG | Masked base of each region, region i in bits [32*i +: 32], ROM last |
| region_valid | output | NREG | Window valid flag of each region, ROM in the top bit |

## Verification
A read and a write can be accepted on the same edge, and they may address the same register. The bench drives cfg_wr and cfg_rd together to one address register and expects the old contents in cfg_rdata. A following plain read must then return the new value. The same collision, where the read register update and the store update share one edge, is also where a command write changes the validity of all regions at once. The bench checks that case by flipping the enables while several windows hold non-zero bases and comparing every flag one cycle later.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [32:0] IO_LIMIT = 33'h1_0000;

  // Window check shared by all regions: non-zero base, no carry past the
  // 32-bit space, and for I/O an end below the 64 KiB boundary.
  function automatic logic window_ok(input logic [31:0] base,
                                     input logic [31:0] size,
                                     input logic        is_io);
    logic [32:0] last;
    last = {1'b0, base} + {1'b0, size} - 33'd1;
    window_ok = (base != 32'd0) && !last[32] && !(is_io && (last >= IO_LIMIT));
  endfunction

endpackage

// File: rtl/cfgbar_slot.sv
module cfgbar_slot
  import cfgbar_pkg::*;
#(
  parameter logic [31:0] SIZE   = 32'h10,
  parameter bit          IS_IO  = 1'b0,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        io_en,
  input  logic        mem_en,
  output logic [31:0] raw_q,
  output logic [31:0] rd_val,
  output logic [31:0] base_q,
  output logic        valid_q
);

  localparam logic [31:0] ADDR_MASK = ~(SIZE - 32'd1);
  localparam logic [31:0] KEEP_MASK = IS_ROM ? (ADDR_MASK | 32'd1) : ADDR_MASK;
  localparam logic [31:0] TYPE_BIT  = (IS_IO && !IS_ROM) ? 32'd1 : 32'd0;
  localparam bit          WIN_IO    = IS_IO && !IS_ROM;

  logic [31:0] base_c;
  logic        space_en;

  always_ff @(posedge clk) begin
    if (rst)        raw_q <= 32'd0;
    else if (wr_en) raw_q <= wdata & KEEP_MASK;
  end

  always_comb begin
    base_c = raw_q & ADDR_MASK;
    if (IS_ROM)     space_en = mem_en & raw_q[0];
    else if (IS_IO) space_en = io_en;
    else            space_en = mem_en;
  end

  assign rd_val = raw_q | TYPE_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= 32'd0;
      valid_q <= 1'b0;
    end else begin
      base_q  <= base_c;
      valid_q <= space_en && window_ok(base_c, SIZE, WIN_IO);
    end
  end

endmodule

// File: rtl/cfgbar_bank.sv
module cfgbar_bank
  import cfgbar_pkg::*;
#(
  parameter int                       NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0]   BAR_SIZE = {32'h0001_0000, 32'h0000_0004,
                                                  32'h0010_0000, 32'h0000_0100,
                                                  32'h0000_1000, 32'h0000_0010},
  parameter logic [NUM_BARS-1:0]      BAR_IO   = 6'b010101,
  parameter logic [31:0]              ROM_SIZE = 32'h0001_0000,
  localparam int                      NREG     = NUM_BARS + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [7:0]         cfg_addr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [NREG*32-1:0] region_base,
  output logic [NREG-1:0]    region_valid
);

  localparam logic [5:0] CMD_WORD = 6'd1;
  localparam logic [5:0] BAR_WORD = 6'd4;
  localparam logic [5:0] ROM_WORD = 6'd12;

  logic [5:0]         word;
  logic               aligned;
  logic               wr_full;
  logic [1:0]         cmd_q;
  logic [31:0]        rd_vals [NREG];
  logic [NREG*32-1:0] raw_all;
  logic [31:0]        rd_mux;

  assign word    = cfg_addr[7:2];
  assign aligned = (cfg_addr[1:0] == 2'b00);
  assign wr_full = cfg_wr && aligned && (cfg_be == 4'hF);

  // Command enables: only byte lane 0 bits 1:0 are implemented.
  always_ff @(posedge clk) begin
    if (rst) cmd_q <= 2'b00;
    else if (cfg_wr && aligned && cfg_be[0] && (word == CMD_WORD))
      cmd_q <= cfg_wdata[1:0];
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [5:0] MY_WORD = BAR_WORD + 6'(i);
    cfgbar_slot #(
      .SIZE   (BAR_SIZE[i*32 +: 32]),
      .IS_IO  (BAR_IO[i]),
      .IS_ROM (1'b0)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_full && (word == MY_WORD)),
      .wdata   (cfg_wdata),
      .io_en   (cmd_q[0]),
      .mem_en  (cmd_q[1]),
      .raw_q   (raw_all[i*32 +: 32]),
      .rd_val  (rd_vals[i]),
      .base_q  (region_base[i*32 +: 32]),
      .valid_q (region_valid[i])
    );
  end

  cfgbar_slot #(
    .SIZE   (ROM_SIZE),
    .IS_IO  (1'b0),
    .IS_ROM (1'b1)
  ) u_rom (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_full && (word == ROM_WORD)),
    .wdata   (cfg_wdata),
    .io_en   (cmd_q[0]),
    .mem_en  (cmd_q[1]),
    .raw_q   (raw_all[NUM_BARS*32 +: 32]),
    .rd_val  (rd_vals[NUM_BARS]),
    .base_q  (region_base[NUM_BARS*32 +: 32]),
    .valid_q (region_valid[NUM_BARS])
  );

  always_comb begin
    rd_mux = 32'd0;
    if (word == CMD_WORD) rd_mux = {30'd0, cmd_q};
    for (int i = 0; i < NUM_BARS; i++) begin
      if (word == BAR_WORD + 6'(i)) rd_mux = rd_vals[i];
    end
    if (word == ROM_WORD) rd_mux = rd_vals[NUM_BARS];
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= 32'd0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/cfgbar_bank_chk.sv
module cfgbar_bank_chk #(
  parameter int                     NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE = '0,
  parameter logic [NUM_BARS-1:0]    BAR_IO   = '0,
  localparam int                    NREG     = NUM_BARS + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr,
  input logic [3:0]         cfg_be,
  input logic [1:0]         cmd_q,
  input logic [NREG*32-1:0] raw_all,
  input logic [NREG*32-1:0] region_base,
  input logic [NREG-1:0]    region_valid
);

  localparam logic [NREG-1:0] IO_MASK  = {1'b0, BAR_IO};
  localparam logic [NREG-1:0] MEM_MASK = ~IO_MASK;

  p_partial_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_be != 4'hF)) |=> $stable(raw_all));

  p_io_needs_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_q[0] |=> ((region_valid & IO_MASK) == '0));

  p_mem_needs_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_q[1] |=> ((region_valid & MEM_MASK) == '0));

  p_rom_enable_r9: assert property (@(posedge clk) disable iff (rst)
    region_valid[NUM_BARS] |-> $past(raw_all[NUM_BARS*32]));

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    p_base_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
      region_valid[i] |-> (region_base[i*32 +: 32] != 32'd0));
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_io
    if (BAR_IO[i]) begin : g_lim
      p_io_limit_r8: assert property (@(posedge clk) disable iff (rst)
        region_valid[i] |->
          (({1'b0, region_base[i*32 +: 32]} + {1'b0, BAR_SIZE[i*32 +: 32]}) <= 33'h1_0000));
    end
  end

endmodule

bind cfgbar_bank cfgbar_bank_chk #(
  .NUM_BARS (NUM_BARS),
  .BAR_SIZE (BAR_SIZE),
  .BAR_IO   (BAR_IO)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_wr       (cfg_wr),
  .cfg_be       (cfg_be),
  .cmd_q        (cmd_q),
  .raw_all      (raw_all),
  .region_base  (region_base),
  .region_valid (region_valid)
);

// File: tb/test_cfgbar_bank.sv
module test_cfgbar_bank;

  localparam int NREG = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0;
  logic              cfg_rd = 1'b0;
  logic [7:0]        cfg_addr = 8'd0;
  logic [3:0]        cfg_be = 4'h0;
  logic [31:0]       cfg_wdata = 32'd0;
  logic [31:0]       cfg_rdata;
  logic [NREG*32-1:0] region_base;
  logic [NREG-1:0]   region_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cfgbar_bank i_cfgbar_bank (
    .clk (clk), .rst (rst), .cfg_wr (cfg_wr), .cfg_rd (cfg_rd),
    .cfg_addr (cfg_addr), .cfg_be (cfg_be), .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata), .region_base (region_base), .region_valid (region_valid)
  );

  // Sizes and kinds as the requirements give them for the default build.
  function automatic logic [31:0] size_of(input int i);
    case (i)
      0: size_of = 32'h10;      1: size_of = 32'h1000;
      2: size_of = 32'h100;     3: size_of = 32'h10_0000;
      4: size_of = 32'h4;       5: size_of = 32'h1_0000;
      default: size_of = 32'h1_0000;
    endcase
  endfunction

  function automatic bit is_io(input int i);
    is_io = (i == 0) || (i == 2) || (i == 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [31:0] base_of(input int i);
    base_of = region_base[i*32 +: 32];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    eq("R1 valid", 32'(region_valid), 32'd0);
    eq("R1 rdata", cfg_rdata, 32'd0);
    rd(8'h04, d); eq("R1 command", d, 32'd0);
    rd(8'h10, d); eq("R1 bar0 (io bit)", d, 32'd1);
    rd(8'h30, d); eq("R1 rom", d, 32'd0);
  endtask

  task automatic t_sizing();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin
      wr(8'(8'h10 + 4*i), 4'hF, 32'hFFFF_FFFF);
      rd(8'(8'h10 + 4*i), d);
      eq("R4 sizing readback", d, ~(size_of(i) - 32'd1) | (is_io(i) ? 32'd1 : 32'd0));
      wr(8'(8'h10 + 4*i), 4'hF, 32'd0);
    end
    wr(8'h30, 4'hF, 32'hFFFF_FFFF);
    rd(8'h30, d); eq("R5 rom sizing", d, 32'hFFFF_0001);
    wr(8'h30, 4'hF, 32'd0);
  endtask

  task automatic t_store();
    logic [31:0] d;
    wr(8'h14, 4'hF, 32'h1234_5678);
    rd(8'h14, d); eq("R2 mem store masked", d, 32'h1234_5000);
    wr(8'h10, 4'hF, 32'h0000_C0F7);
    rd(8'h10, d); eq("R2 io store masked", d, 32'h0000_C0F1);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    wr(8'h14, 4'b0011, 32'hAAAA_5555);
    rd(8'h14, d); eq("R3 partial write ignored", d, 32'h1234_5000);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd(8'h04, d); eq("R6 command readback", d, 32'd3);
    wr(8'h04, 4'hF, 32'd0); settle();
    eq("R6 no enables", 32'(region_valid), 32'd0);
    wr(8'h04, 4'hF, 32'd1); settle();
    eq("R6 io only bar0", 32'(region_valid[0]), 32'd1);
    eq("R6 io only bar1", 32'(region_valid[1]), 32'd0);
    eq("R10 io base", base_of(0), 32'h0000_C0F0);
    wr(8'h04, 4'hF, 32'd2); settle();
    eq("R6 mem only bar0", 32'(region_valid[0]), 32'd0);
    eq("R6 mem only bar1", 32'(region_valid[1]), 32'd1);
    eq("R10 mem base", base_of(1), 32'h1234_5000);
    wr(8'h04, 4'hF, 32'd3); settle();
    eq("R6 both enabled", 32'(region_valid[1:0]), 32'd3);
  endtask

  task automatic t_zero();
    wr(8'h14, 4'hF, 32'd0); settle();
    eq("R7 zero base bar1", 32'(region_valid[1]), 32'd0);
    eq("R7 never written bar3", 32'(region_valid[3]), 32'd0);
  endtask

  task automatic t_io_limit();
    wr(8'h18, 4'hF, 32'h0000_FF00); settle();
    eq("R8 io ends at FFFF", 32'(region_valid[2]), 32'd1);
    wr(8'h18, 4'hF, 32'h0001_0000); settle();
    eq("R8 io beyond 64K", 32'(region_valid[2]), 32'd0);
    wr(8'h20, 4'hF, 32'h0000_FFFC); settle();
    eq("R8 small io at top", 32'(region_valid[4]), 32'd1);
  endtask

  task automatic t_rom();
    logic [31:0] d;
    wr(8'h30, 4'hF, 32'hABCD_1235);
    rd(8'h30, d); eq("R5 rom keeps enable", d, 32'hABCD_0001);
    eq("R9 rom valid", 32'(region_valid[6]), 32'd1);
    eq("R10 rom base clears enable", base_of(6), 32'hABCD_0000);
    wr(8'h04, 4'hF, 32'd1); settle();
    eq("R9 rom needs memory enable", 32'(region_valid[6]), 32'd0);
    wr(8'h04, 4'hF, 32'd3);
    wr(8'h30, 4'hF, 32'hABCD_0000); settle();
    eq("R9 rom disabled", 32'(region_valid[6]), 32'd0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(8'h1C, 4'hF, 32'h4000_0000);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_addr = 8'h1C; cfg_be = 4'hF; cfg_wdata = 32'h8000_0000;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_be = 4'h0;
    eq("R11 read returns old value", cfg_rdata, 32'h4000_0000);
    rd(8'h1C, d); eq("R11 later read new value", d, 32'h8000_0000);
  endtask

  task automatic t_timing();
    wr(8'h24, 4'hF, 32'h0005_0000);
    eq("R10 not yet updated", 32'(region_valid[5]), 32'd0);
    @(negedge clk);
    eq("R10 updated next edge", 32'(region_valid[5]), 32'd1);
    eq("R10 base updated", base_of(5), 32'h0005_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizing();
    t_store();
    t_partial();
    t_cmd();
    t_zero();
    t_io_limit();
    t_rom();
    t_same_cycle();
    t_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule